// File: doc/BRIEF.md
# Programmable-Width SPI Master

This block is a register-programmed serial peripheral master that moves one character at a time. Software writes a configuration word that sets the clock phase, the clock idle level, the bit order, an internal loopback path, the character width and a two-stage baud divider. A word written to the data register then goes out on `mosi` while `miso` is sampled. The received word appears in the same data register.

Two event flags track the transfer: one says a received word is waiting, the other says the transmit holding register can take a word. Each flag can be routed to a single interrupt line through a mask register. Chip selects are not part of this block. The surrounding system drives them as ordinary outputs around each transfer.

The register bus is a plain synchronous write strobe with a combinational read. The word offsets are 0 for configuration, 1 for events, 2 for the interrupt mask and 3 for transmit/receive data.

Top module: `spi_master_ctl`

## Requirements
- R1: The clock divider uses `pm` (config bits 15:12) and `slow` (bit 16). While a character is moving, each half period of `sck` lasts 2×(pm+1) clock cycles when `slow` is 0, and 32×(pm+1) cycles when it is 1. A full `sck` period is therefore 4×(pm+1) or 64×(pm+1) cycles.
- R2: The width code in config bits 11:8 gives a character of code+1 bits for codes 3 to 15. Code 0 gives a 32-bit character.
- R3: A config write whose width code is 1 or 2 leaves the stored width code unchanged. All other fields of that write still take effect.
- R4: Config bit 2 sets the idle level of `sck`. With config bit 1 clear, data is sampled on the first edge of each bit and changed on the second. With config bit 1 set, data is changed on the first edge and sampled on the second.
- R5: With config bit 3 set, the character is shifted most significant bit first. With it clear, it is shifted least significant bit first. This applies to both directions.
- R6: With config bit 4 set, the receive path takes `mosi` instead of `miso`.
- R7: Config bit 0 enables the block. A data write while it is 0 is ignored. Clearing it during a transfer stops `sck` at its idle level, and no receive event follows.
- R8: Event bit 0 (received) sets when a character completes. Reading the data register does not clear it. Event bit 1 (transmit free) is 1 after reset. It clears when a data write is held and sets when that word enters the shifter. Writing 1 to an event bit clears it.
- R9: `irq` is high exactly when some event bit and its matching mask bit (mask bits 1:0) are both 1.
- R10: Characters are right-aligned in the data register. Received bits above the character width read as 0, and transmit bits above the width are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The assertions assume that software changes the divider, the width and the phase settings only while no character is moving. Under that assumption the baud counter stays within its limit, and the edge count matches the width of the character in flight. The stimulus meets this by first writing the configuration with the enable bit clear, then writing it again enabled, and then starting a transfer. The next configuration change comes only after the received event has been seen. In the abort case, only the enable bit is cleared; the other fields are left untouched.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
   localparam int WORD_W = 32;
   localparam int PM_W   = 4;
   localparam int CODE_W = 4;
   localparam int LEN_W  = 6;

   typedef struct packed {
      logic [14:0]       spare_hi;
      logic              slow;
      logic [PM_W-1:0]   pm;
      logic [CODE_W-1:0] width_code;
      logic [2:0]        spare_lo;
      logic              loopback;
      logic              msb_first;
      logic              idle_high;
      logic              late_phase;
      logic              enable;
   } mode_t;

   typedef enum logic [1:0] {
      A_MODE  = 2'd0,
      A_EVENT = 2'd1,
      A_MASK  = 2'd2,
      A_DATA  = 2'd3
   } reg_addr_e;

   function automatic logic [LEN_W-1:0] code_to_len(input logic [CODE_W-1:0] c);
      return (c == '0) ? LEN_W'(WORD_W) : LEN_W'(c) + LEN_W'(1);
   endfunction

   function automatic logic code_legal(input logic [CODE_W-1:0] c);
      return (c == '0) || (c >= CODE_W'(3));
   endfunction

   function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] n);
      return (n >= LEN_W'(WORD_W)) ? '1 : (WORD_W'(1) << n) - WORD_W'(1);
   endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int PM_BITS  = 4,
   parameter int SLOW_DIV = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PM_BITS-1:0] pm,
   input  logic               slow,
   output logic               tick
);
   localparam int FAST_HALF = 2;
   localparam int SLOW_HALF = 2 * SLOW_DIV;
   localparam int MAX_HALF  = SLOW_HALF * (2 ** PM_BITS);
   localparam int CNT_W     = $clog2(MAX_HALF);

   generate
      if (SLOW_DIV < 2 || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_div
         $error("SLOW_DIV must be a power of two of at least 2");
      end
      if (PM_BITS < 1 || PM_BITS > 8) begin : g_bad_pm
         $error("PM_BITS out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, limit;

   always_comb limit = CNT_W'((slow ? SLOW_HALF : FAST_HALF) * (int'(pm) + 1) - 1);
   assign tick = run && (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || tick)  cnt <= '0;
      else                    cnt <= cnt + CNT_W'(1);
   end

   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= limit));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [LEN_W-1:0]  len,
   input  logic              late_phase,
   input  logic              idle_high,
   input  logic              msb_first,
   input  logic              loopback,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              taken,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sck,
   output logic              mosi
);
   localparam int EDGE_W = LEN_W + 1;

   logic [WORD_W-1:0] tx_sr, rx_sr, rx_sh, tx_sh, rx_nxt;
   logic [EDGE_W-1:0] edge_cnt;
   logic              phase, lead, last, samp, shf, din;
   logic [LEN_W-2:0]  top_idx;

   assign top_idx = (LEN_W-1)'(len - LEN_W'(1));
   assign mosi    = msb_first ? tx_sr[top_idx] : tx_sr[0];
   assign din     = loopback ? mosi : miso;
   assign sck     = idle_high ^ phase;

   assign lead  = ~edge_cnt[0];
   assign last  = edge_cnt == ({len, 1'b0} - EDGE_W'(1));
   assign samp  = late_phase ? !lead : lead;
   assign shf   = late_phase ? (lead && edge_cnt != '0) : (!lead && !last);

   always_comb begin
      rx_sh  = msb_first ? {rx_sr[WORD_W-2:0], din} : {din, rx_sr[WORD_W-1:1]};
      tx_sh  = msb_first ? (tx_sr << 1) : (tx_sr >> 1);
      rx_nxt = samp ? rx_sh : rx_sr;
      rx_word = msb_first ? rx_nxt : (rx_nxt >> (LEN_W'(WORD_W) - len));
   end

   assign taken = en && !busy && start;
   assign done  = en && busy && tick && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0; phase <= 1'b0; edge_cnt <= '0;
         tx_sr <= '0; rx_sr <= '0;
      end else if (!en) begin
         busy <= 1'b0; phase <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            tx_sr <= tx_word; rx_sr <= '0; edge_cnt <= '0;
            phase <= 1'b0; busy <= 1'b1;
         end
      end else if (tick) begin
         phase    <= ~phase;
         edge_cnt <= edge_cnt + EDGE_W'(1);
         if (samp) rx_sr <= rx_sh;
         if (shf)  tx_sr <= tx_sh;
         if (last) busy  <= 1'b0;
      end
   end

   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == idle_high));
   assert_disable_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (edge_cnt < {len, 1'b0}));
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
   import spi_ctl_pkg::*;
#(
   parameter int SLOW_DIV = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        sck,
   output logic        mosi,
   input  logic        miso,
   output logic        irq
);
   mode_t             mode_q, mode_nxt;
   logic              ev_ne, ev_nf, msk_ne, msk_nf, pend_q;
   logic [WORD_W-1:0] hold_q, rx_q, rx_word;
   logic [LEN_W-1:0]  len;
   logic              wr_mode, wr_evt, wr_msk, wr_data, tx_acc;
   logic              busy, taken, done, tick;

   assign wr_mode = wr_en && (addr == A_MODE);
   assign wr_evt  = wr_en && (addr == A_EVENT);
   assign wr_msk  = wr_en && (addr == A_MASK);
   assign wr_data = wr_en && (addr == A_DATA);
   assign tx_acc  = wr_data && mode_q.enable && !pend_q;
   assign len     = code_to_len(mode_q.width_code);

   always_comb begin
      mode_nxt          = mode_t'(wdata);
      mode_nxt.spare_hi = '0;
      mode_nxt.spare_lo = '0;
      if (!code_legal(mode_nxt.width_code)) mode_nxt.width_code = mode_q.width_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0; ev_ne <= 1'b0; ev_nf <= 1'b1;
         msk_ne <= 1'b0; msk_nf <= 1'b0; pend_q <= 1'b0;
         hold_q <= '0; rx_q <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_nxt;
         if (wr_msk) begin msk_ne <= wdata[0]; msk_nf <= wdata[1]; end
         if (tx_acc) hold_q <= wdata;
         if (done)   rx_q   <= rx_word;
         if (!mode_q.enable || taken) pend_q <= 1'b0;
         else if (tx_acc)             pend_q <= 1'b1;
         if (done)                      ev_ne <= 1'b1;
         else if (wr_evt && wdata[0])   ev_ne <= 1'b0;
         if (taken)                                ev_nf <= 1'b1;
         else if (tx_acc || (wr_evt && wdata[1]))  ev_nf <= 1'b0;
      end
   end

   always_comb begin
      unique case (addr)
         A_MODE:  rdata = mode_q;
         A_EVENT: rdata = {30'b0, ev_nf, ev_ne};
         A_MASK:  rdata = {30'b0, msk_nf, msk_ne};
         default: rdata = rx_q;
      endcase
   end

   assign irq = (ev_ne && msk_ne) || (ev_nf && msk_nf);

   spi_baud_gen #(.PM_BITS(PM_W), .SLOW_DIV(SLOW_DIV)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .pm(mode_q.pm),
      .slow(mode_q.slow), .tick(tick));

   spi_shift_engine u_shift (
      .clk(clk), .rst_n(rst_n), .en(mode_q.enable), .start(pend_q),
      .tx_word(hold_q), .len(len), .late_phase(mode_q.late_phase),
      .idle_high(mode_q.idle_high), .msb_first(mode_q.msb_first),
      .loopback(mode_q.loopback), .tick(tick), .miso(miso),
      .busy(busy), .taken(taken), .done(done), .rx_word(rx_word),
      .sck(sck), .mosi(mosi));

   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ev_ne || ev_nf));
   assert_ne_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_ne) |-> $past(done));
   assert_rx_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((rx_word & ~len_mask(len)) == '0));
endmodule

// File: tb/tb_spi_master_ctl.sv
module tb_spi_master_ctl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0, rdata;
   logic        sck, mosi, irq;
   int          n_chk = 0, n_fail = 0, tog_cnt = 0;
   time         t_last = 0, t_prev = 0;

   spi_master_ctl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(sck) begin
      tog_cnt = tog_cnt + 1;
      t_prev  = t_last;
      t_last  = $time;
   end

   function automatic int exp_len(input logic [3:0] c);
      return (c == 0) ? 32 : int'(c) + 1;
   endfunction
   function automatic logic [31:0] exp_mask(input int n);
      return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
   endfunction
   function automatic logic [31:0] mk_mode(input bit en, cpha, cpol, msb, lp,
                                           input logic [3:0] lc, pm, input bit slow);
      return {15'b0, slow, pm, lc, 3'b0, lp, msb, cpol, cpha, en};
   endfunction
   function automatic int bpos(input bit msb, input int n, input int i);
      return msb ? (n - 1 - i) : i;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask
   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask
   task automatic wait_ne();
      logic [31:0] d;
      for (int k = 0; k < 40000; k++) begin
         rd(2'd1, d);
         if (d[0]) break;
      end
   endtask
   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input bit cpha, cpol, msb, lp, input logic [3:0] lc, pm,
                       input bit slow, input logic [31:0] tx, sw, input string tag);
      int n = exp_len(lc);
      logic [31:0] m = exp_mask(n);
      logic [31:0] got = '0;
      logic [31:0] d;
      wr(2'd0, mk_mode(0, cpha, cpol, msb, lp, lc, pm, slow));
      wr(2'd0, mk_mode(1, cpha, cpol, msb, lp, lc, pm, slow));
      wr(2'd1, 32'h1);
      if (!cpha) miso = sw[bpos(msb, n, 0)];
      fork
         begin
            for (int e = 0; e < 2 * n; e++) begin
               int idx;
               @(sck);
               idx = e / 2;
               if (sck != cpol) begin
                  if (!cpha) got[bpos(msb, n, idx)] = mosi;
                  else       miso = sw[bpos(msb, n, idx)];
               end else begin
                  if (!cpha) begin
                     if (idx + 1 < n) miso = sw[bpos(msb, n, idx + 1)];
                  end else got[bpos(msb, n, idx)] = mosi;
               end
            end
         end
         begin
            wr(2'd3, tx);
            wait_ne();
         end
      join
      settle(1);
      rd(2'd3, d);
      chk(d == (lp ? (tx & m) : (sw & m)), {tag, " received word"}, d, lp ? (tx & m) : (sw & m));
      chk(got == (tx & m), {tag, " bits seen on mosi"}, got, tx & m);
   endtask

   initial begin
      logic [31:0] d;
      int base;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // Reset state
      rd(2'd0, d); chk(d == 32'h0, "R7 reset config", d, 32'h0);
      rd(2'd1, d); chk(d == 32'h2, "R8 reset events", d, 32'h2);
      rd(2'd3, d); chk(d == 32'h0, "R10 reset data", d, 32'h0);
      chk(irq == 1'b0, "R9 reset irq", {31'b0, irq}, 32'h0);

      // R3: illegal width code keeps the previous one
      wr(2'd0, mk_mode(0, 0, 0, 1, 0, 4'd7, 4'd0, 0));
      wr(2'd0, mk_mode(0, 0, 0, 1, 1, 4'd2, 4'd0, 0));
      rd(2'd0, d);
      chk(d[11:8] == 4'd7 && d[4], "R3 illegal width code ignored", d, mk_mode(0, 0, 0, 1, 1, 4'd7, 4'd0, 0));

      // R4: idle level follows config bit 2
      wr(2'd0, mk_mode(1, 0, 1, 1, 0, 4'd7, 4'd0, 0));
      settle(1);
      chk(sck == 1'b1, "R4 idle-high sck", {31'b0, sck}, 32'h1);

      // Directed transfers over phase, polarity, order, width
      xfer(0, 0, 1, 0, 4'd7,  4'd0, 0, 32'hFFFF_FFA5, 32'h0000_003C, "R5 R10 msb-first 8-bit");
      xfer(0, 0, 0, 0, 4'd7,  4'd1, 0, 32'h0000_00B1, 32'h0000_00E4, "R5 lsb-first 8-bit");
      xfer(1, 0, 1, 0, 4'd15, 4'd0, 0, 32'h0000_C3A5, 32'h0000_5A0F, "R4 late phase 16-bit");
      xfer(1, 1, 0, 0, 4'd3,  4'd0, 0, 32'h0000_0019, 32'h0000_0006, "R4 idle-high late phase 4-bit");
      xfer(0, 1, 1, 0, 4'd0,  4'd0, 0, 32'hDEAD_BEEF, 32'h1234_5678, "R2 32-bit msb-first");
      xfer(1, 0, 0, 0, 4'd0,  4'd0, 0, 32'h8000_0001, 32'hC001_D00D, "R2 32-bit lsb-first");
      xfer(0, 0, 1, 1, 4'd11, 4'd0, 0, 32'h0000_0ABC, 32'h0000_0555, "R6 loopback 12-bit");

      // R1: half-period timing
      xfer(0, 0, 1, 0, 4'd3, 4'd2, 0, 32'h5, 32'hA, "R1 pm2 fast");
      chk((t_last - t_prev) == 6 * CLK_PERIOD, "R1 half period pm=2 fast",
          32'(t_last - t_prev), 32'(6 * CLK_PERIOD));
      xfer(0, 0, 1, 0, 4'd3, 4'd1, 1, 32'h3, 32'hC, "R1 pm1 slow");
      chk((t_last - t_prev) == 64 * CLK_PERIOD, "R1 half period pm=1 slow",
          32'(t_last - t_prev), 32'(64 * CLK_PERIOD));

      // R8 / R9: event behaviour, queued word, interrupt mask
      wr(2'd0, mk_mode(1, 0, 0, 1, 1, 4'd3, 4'd3, 0));
      wr(2'd1, 32'h3);
      wr(2'd3, 32'h9);
      wr(2'd3, 32'h6);
      rd(2'd1, d);
      chk(d[1] == 1'b0, "R8 transmit-free clear while word held", d, 32'h0);
      wait_ne();
      wr(2'd1, 32'h1);
      wait_ne();
      settle(2);
      rd(2'd1, d);
      chk(d == 32'h3, "R8 both events set after queued word", d, 32'h3);
      rd(2'd3, d); rd(2'd3, d);
      chk(d == 32'h6, "R8 queued word received", d, 32'h6);
      rd(2'd1, d);
      chk(d[0] == 1'b1, "R8 data read leaves received flag", d, 32'h3);
      chk(irq == 1'b0, "R9 irq masked off", {31'b0, irq}, 32'h0);
      wr(2'd2, 32'h1); settle(1);
      chk(irq == 1'b1, "R9 irq with received mask", {31'b0, irq}, 32'h1);
      wr(2'd1, 32'h1); settle(1);
      chk(irq == 1'b0, "R9 irq drops after event clear", {31'b0, irq}, 32'h0);
      rd(2'd1, d);
      chk(d == 32'h2, "R8 write-one clears received flag", d, 32'h2);
      wr(2'd2, 32'h2); settle(1);
      chk(irq == 1'b1, "R9 irq with transmit-free mask", {31'b0, irq}, 32'h1);
      wr(2'd2, 32'h0);

      // R7: abort and writes while disabled
      wr(2'd0, mk_mode(1, 0, 0, 1, 0, 4'd0, 4'd15, 0));
      wr(2'd3, 32'h1234_5678);
      settle(100);
      wr(2'd0, mk_mode(0, 0, 0, 1, 0, 4'd0, 4'd15, 0));
      settle(2);
      chk(sck == 1'b0, "R7 sck idle after abort", {31'b0, sck}, 32'h0);
      base = tog_cnt;
      wr(2'd3, 32'hFFFF_0000);
      settle(200);
      chk(tog_cnt == base, "R7 no clock while disabled", 32'(tog_cnt), 32'(base));
      rd(2'd1, d);
      chk(d == 32'h2, "R7 no received event after abort", d, 32'h2);

      // Random transfers
      for (int r = 0; r < 24; r++) begin
         int l = $urandom_range(0, 13);
         logic [3:0] lc = (l == 0) ? 4'd0 : 4'(l + 2);
         xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 4) == 0), lc, 4'($urandom_range(0, 3)), 0,
              $urandom, $urandom, "R5 R10 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule